// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

This block is a single pulse-width modulation timer channel. Software, through a bus decoder that lives outside the block, writes a period value and a threshold value into two buffer registers. These buffers have no effect on the waveform until they are copied into the working registers. A copy happens in two ways. A manual load copies them while the channel is held. An automatic reload copies them each time the down-counter finishes a period. While the channel runs, the counter steps down by one on every cycle in which the prescaler's tick-enable input is high. The output level depends on where the counter stands relative to the working threshold. A one-clock pulse marks the end of each period.

The four control bits reach the block as one nibble. From bit 0 upward they are run, manual load, polarity flip and auto-reload. Clearing auto-reload while the channel runs makes it finish the current period and then halt at its idle level. It stays halted until run is cleared. With polarity flip set, a period of N ticks with a high time of d ticks is programmed as period value N-1 and threshold N-d-1. A threshold of all ones gives a high level for the whole period.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: After reset with a control nibble of zero, both buffers read as zero, `pwm_out` is 0 and `period_end` is 0.
- R2: With auto-reload set, one period lasts (period value + 1) ticks, measured between successive `period_end` pulses.
- R3: With polarity flip set (bit 2 = 1), `pwm_out` is high for (period value - threshold) ticks at the start of each period and low for the rest of the period.
- R4: With polarity flip clear, the waveform is the complement of the R3 waveform: low first, then high for (threshold + 1) ticks.
- R5: A threshold of all ones never matches the counter. With polarity flip set, `pwm_out` is high for every tick of the period, and `period_end` keeps pulsing.
- R6: While manual load (bit 1) is high, both buffers are copied into the working registers and the output sits at its idle level, which equals the polarity flip bit. Once run (bit 0) is set with manual load low, the first `period_end` arrives (period value + 1) ticks later.
- R7: A buffer write alone does not change the period in progress. The new values take effect at the next reload.
- R8: When auto-reload (bit 3) is clear, the channel completes the current period, gives exactly one `period_end` pulse and then halts. The output holds its idle level, and setting auto-reload again does not restart the channel while run stays set.
- R9: `period_end` is high for one clock, in the clock after the tick on which the counter stood at zero.
- R10: In a cycle without tick-enable the working registers hold their values, so the period and the high time scale with the tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_nib | input | 4 | Control bits: 0 run, 1 manual load, 2 polarity flip, 3 auto-reload |
| tick_en | input | 1 | Prescaler tick; the counter advances only when high |
| cnt_wr | input | 1 | Write strobe for the period buffer |
| cmp_wr | input | 1 | Write strobe for the threshold buffer |
| wr_data | input | CNT_W | Data for the buffer writes |
| pwm_out | output | 1 | PWM waveform |
| period_end | output | 1 | One-clock pulse at the end of each period |

## Verification
The bench measures the period length and the high time over many random settings of period, duty, polarity and tick spacing. A wrong decrement or reload shows up as a wrong pulse spacing, and an off-by-one in the threshold comparison shifts the high time by one tick. Directed cases cover four faults. An all-ones threshold handled as an ordinary value would lose the full-duty level. A buffer write that leaks into the working registers would shorten the period in progress. A manual load that failed to restart the counter would move the first pulse. A channel that ignored a cleared auto-reload would keep pulsing, or would come back to life when the bit is set again.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    // Control nibble, MSB first: bit 3 reload, bit 2 flip, bit 1 manual, bit 0 run
    typedef struct packed {
        logic reload;
        logic flip;
        logic manual;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = 4;

    function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
        return ctrl_t'(w);
    endfunction

    // Working register set loaded from the buffers
    function automatic logic is_all_ones(input logic [63:0] v, input int w);
        logic r;
        r = 1'b1;
        for (int i = 0; i < w; i++) r &= v[i];
        return r;
    endfunction

endpackage

// File: rtl/pwm_dbuf_bufregs.sv
module pwm_dbuf_bufregs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_buf,
    output logic [CNT_W-1:0] cmp_buf
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_buf <= '0;
            cmp_buf <= '0;
        end else begin
            if (cnt_wr) cnt_buf <= wr_data;
            if (cmp_wr) cmp_buf <= wr_data;
        end
    end

    AST_BUF_WRITE: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> cnt_buf == $past(wr_data)); // R7

endmodule

// File: rtl/pwm_dbuf_counter.sv
module pwm_dbuf_counter
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             active,
    output logic             period_end
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic halted_q;
    logic at_zero;

    assign active  = ctrl.run & ~ctrl.manual & ~halted_q;
    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            cmp_q      <= '0;
            halted_q   <= 1'b0;
            period_end <= 1'b0;
        end else begin
            period_end <= 1'b0;
            if (ctrl.manual) begin
                cnt_q    <= cnt_buf;
                cmp_q    <= cmp_buf;
                halted_q <= 1'b0;
            end else if (!ctrl.run) begin
                halted_q <= 1'b0;
            end else if (!halted_q && tick_en) begin
                if (at_zero) begin
                    period_end <= 1'b1;
                    if (ctrl.reload) begin
                        cnt_q <= cnt_buf;
                        cmp_q <= cmp_buf;
                    end else begin
                        halted_q <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end

    AST_MANUAL_LOAD: assert property (@(posedge clk) disable iff (rst)
        ctrl.manual |=> (cnt_q == $past(cnt_buf)) && (cmp_q == $past(cmp_buf))); // R6

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.manual && !tick_en) |=> $stable(cnt_q) && $stable(cmp_q)); // R10

    AST_PE_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
        period_end |-> $past(active && tick_en && at_zero)); // R9

    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (active && tick_en && !at_zero) |=> cnt_q == $past(cnt_q) - ONE); // R2

    AST_HALT_STICKS: assert property (@(posedge clk) disable iff (rst)
        (halted_q && ctrl.run && !ctrl.manual) |=> !active && !period_end); // R8

endmodule

// File: rtl/pwm_dbuf_outstage.sv
module pwm_dbuf_outstage #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cmp_q,
    input  logic             active,
    input  logic             flip,
    output logic             pwm_out
);

    logic never_match;
    logic raw_lvl;

    assign never_match = &cmp_q;
    assign raw_lvl     = active & ~never_match & (cnt_q <= cmp_q);
    assign pwm_out     = raw_lvl ^ flip;

endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       ctrl_nib,
    input  logic             tick_en,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             period_end
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] cnt_buf, cmp_buf;
    logic [CNT_W-1:0] cnt_q, cmp_q;
    logic             active;

    assign ctrl = decode_ctrl(ctrl_nib);

    pwm_dbuf_bufregs #(.CNT_W(CNT_W)) u_buf (
        .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .cmp_wr(cmp_wr),
        .wr_data(wr_data), .cnt_buf(cnt_buf), .cmp_buf(cmp_buf)
    );

    pwm_dbuf_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .ctrl(ctrl), .tick_en(tick_en),
        .cnt_buf(cnt_buf), .cmp_buf(cmp_buf), .cnt_q(cnt_q), .cmp_q(cmp_q),
        .active(active), .period_end(period_end)
    );

    pwm_dbuf_outstage #(.CNT_W(CNT_W)) u_out (
        .cnt_q(cnt_q), .cmp_q(cmp_q), .active(active), .flip(ctrl.flip),
        .pwm_out(pwm_out)
    );

endmodule

// File: tb/pwm_dbuf_channel_tb.sv
module pwm_dbuf_channel_tb_top;

    localparam int W = 16;
    localparam int LIMIT = 150000;
    localparam logic [3:0] B_RUN = 4'b0001, B_MAN = 4'b0010,
                           B_FLIP = 4'b0100, B_AR = 4'b1000; // R11 layout

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] ctrl_nib = '0;
    logic tick_en = 1'b1;
    logic cnt_wr = 1'b0, cmp_wr = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic pwm_out, period_end;

    int checks = 0, fails = 0, cyc = 0, phase = 0, gap = 1;
    bit to = 1'b0;

    always #10 clk = ~clk;

    pwm_dbuf_channel #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .ctrl_nib(ctrl_nib), .tick_en(tick_en),
        .cnt_wr(cnt_wr), .cmp_wr(cmp_wr), .wr_data(wr_data),
        .pwm_out(pwm_out), .period_end(period_end)
    );

    function automatic int cmp_for(int n, int d);
        return (d >= n) ? 32'h0000FFFF : n - d - 1;
    endfunction

    function automatic int exp_high(int n, int d, bit flip, int g);
        if (d >= n) return flip ? n * g : 0;
        return flip ? d * g : (n - d) * g;
    endfunction

    task automatic step();
        @(negedge clk);
        phase++;
        tick_en = (gap <= 1) || (phase % gap == 0);
        cyc++;
        if (cyc > LIMIT && !to) begin
            to = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, LIMIT);
        end
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_bufs(int cv, int mv);
        wr_data = W'(cv); cnt_wr = 1'b1; step();
        cnt_wr = 1'b0; wr_data = W'(mv); cmp_wr = 1'b1; step();
        cmp_wr = 1'b0;
    endtask

    task automatic wait_pe();
        int k = 0;
        while (!period_end && !to && k < 2000) begin step(); k++; end
    endtask

    // From current negedge (start of a period) until the next period_end.
    // Optionally writes new buffers in the first two cycles.
    task automatic measure(output int n, output int high, input bit wr, input int cv, input int mv);
        n = 0; high = 0;
        do begin
            high += int'(pwm_out);
            if (wr && n == 0) begin wr_data = W'(cv); cnt_wr = 1'b1; end
            if (wr && n == 1) begin cnt_wr = 1'b0; wr_data = W'(mv); cmp_wr = 1'b1; end
            if (wr && n == 2) cmp_wr = 1'b0;
            n++;
            step();
        end while (!period_end && !to && n < 2000);
        cnt_wr = 1'b0; cmp_wr = 1'b0;
    endtask

    task automatic setup(int n, int d, bit flip);
        logic [3:0] f;
        f = flip ? B_FLIP : 4'b0;
        ctrl_nib = f; step();
        load_bufs(n - 1, cmp_for(n, d));
        ctrl_nib = f | B_MAN; step();
        ctrl_nib = f | B_RUN | B_AR;
    endtask

    initial begin
        int n, hi, pes, pe_at;
        bit idle_ok;
        void'($urandom(32'd1234));
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1: reset state
        check("R1 pwm_out", int'(pwm_out), 0);
        check("R1 period_end", int'(period_end), 0);
        ctrl_nib = B_MAN; step();  // copy reset buffers; idle level stays 0
        check("R1 idle after load", int'(pwm_out), 0);
        ctrl_nib = '0; step();

        // R6: manual load then start; first pulse after N ticks; high time R3
        gap = 1;
        setup(7, 3, 1'b1);
        check("R6 idle during load", int'(pwm_out), 1);
        measure(n, hi, 1'b0, 0, 0);
        check("R6 first period length", n, 7);
        check("R3 first period high", hi, 3);

        // Random sweep: R2 R3 R4 R5 R10
        for (int it = 0; it < 10 && !to; it++) begin
            int pn, pd, lg;
            bit fl;
            pn = 2 + int'($urandom % 15);
            pd = (it % 4 == 3) ? pn : 1 + int'($urandom % (pn - 1));
            fl = (it == 0) ? 1'b0 : bit'($urandom % 2);
            lg = 1 + int'($urandom % 3);
            gap = 1;
            setup(pn, pd, fl);
            gap = lg;
            wait_pe();
            measure(n, hi, 1'b0, 0, 0);
            check("R2/R10 period clocks", n, pn * lg);
            if (pd >= pn)      check("R5 full duty high", hi, exp_high(pn, pd, fl, lg));
            else if (fl)       check("R3 high time", hi, exp_high(pn, pd, fl, lg));
            else               check("R4 inverted high time", hi, exp_high(pn, pd, fl, lg));
        end

        // R7: buffer write mid-run affects only the next period
        gap = 1;
        setup(9, 4, 1'b1);
        wait_pe();
        measure(n, hi, 1'b1, 4, cmp_for(5, 2));
        check("R7 current period kept", n, 9);
        check("R7 current high kept", hi, 4);
        measure(n, hi, 1'b0, 0, 0);
        check("R7 new period", n, 5);
        check("R7 new high", hi, 2);

        // R8: clear auto-reload, finish period, halt at idle level
        setup(6, 2, 1'b1);
        wait_pe();
        ctrl_nib = B_RUN | B_FLIP;
        pes = 0; pe_at = -1; idle_ok = 1'b1;
        for (int k = 1; k <= 40 && !to; k++) begin
            step();
            if (period_end) begin pes++; if (pe_at < 0) pe_at = k; end
            if (k > 8 && pwm_out != 1'b1) idle_ok = 1'b0;
        end
        check("R8 single final pulse", pes, 1);
        check("R9 final pulse position", pe_at, 6);
        check("R8 idle level held", int'(idle_ok), 1);
        ctrl_nib = B_RUN | B_FLIP | B_AR;  // no restart while halted
        pes = 0;
        for (int k = 0; k < 20 && !to; k++) begin step(); pes += int'(period_end); end
        check("R8 stays halted", pes, 0);
        check("R8 idle output", int'(pwm_out), 1);

        // R9: pulse width one clock
        setup(4, 1, 1'b0);
        wait_pe();
        step();
        check("R9 pulse width", int'(period_end), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule